// File: doc/BRIEF.md
# Windowed Pixel Output Stage with Bypassable Color Conversion

This block is the last stage of a pixel pipeline. Each pixel slot carries two candidates: the live pixel coming in on the input bus, and a pixel from an expanded-data stream. A per-pixel window flag picks which one reaches the output bus. Inside the window the expanded pixel is used. It can pass through a fixed-coefficient YCbCr-to-RGB stage or go through raw. The window flag and the conversion select are captured together with the pixel they belong to. A change of source or of conversion therefore takes effect on exactly that pixel.

The converted path, the raw expanded path and the pass-through path all have the same depth: three pipeline advances. The output latency is the same whatever mix of window and conversion is chosen. The horizontal and vertical sync inputs travel through the same three-advance delay, so they stay aligned with the pixel data. A pixel-enable input gates every advance of every stage. An output-enable goes high once the pipeline has been filled with real data after reset.

Top module: `pxo_window_out`

## Requirements
- R1: While reset is asserted, and until three advances have been made, `out_pix`, `out_hs` and `out_vs` are 0. The pipeline stages are cleared by reset, so nothing that was on the inputs before reset released can appear at the output.
- R2: `out_oe` is 0 from reset until the third clock edge at which `pix_en` is high. It is 1 from then on until the next reset.
- R3: When the window flag sampled with a pixel is 0, the value seen after the third advance that follows that pixel's sampling is the `in_pix` value sampled with it.
- R4: When the window flag is 1 and the conversion select is 0, the output is the `exp_pix` value sampled with that pixel, after the same three advances.
- R5: When both the window flag and the conversion select are 1, the output is the RGB conversion of `exp_pix`, after the same three advances. The packing is bits [23:16] = Y / R, [15:8] = Cb / G and [7:0] = Cr / B. The conversion uses u = Cb-128 and v = Cr-128. It computes R = Y + floor(359·v/256), G = Y - floor((88·u + 183·v)/256) and B = Y + floor(454·u/256).
- R6: Each converted channel saturates: a result below 0 gives 0, and a result above 255 gives 255.
- R7: `out_hs` and `out_vs` equal the `in_hs` and `in_vs` sampled with the same pixel, after the same three advances.
- R8: The window flag and the conversion select are sampled with each pixel. When they change from one pixel to the next, the output switches source on exactly that pixel, with no change in latency.
- R9: In a cycle with `pix_en` low, no stage advances. `out_pix`, `out_hs`, `out_vs` and `out_oe` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel enable; every pipeline advance needs it high |
| in_pix | input | 24 | Live input pixel |
| in_hs | input | 1 | Horizontal sync, in step with `in_pix` |
| in_vs | input | 1 | Vertical sync, in step with `in_pix` |
| exp_pix | input | 24 | Expanded-stream pixel, YCbCr packed Y/Cb/Cr |
| win | input | 1 | Window flag: 1 inserts the expanded pixel |
| cnv_sel | input | 1 | 1 converts the expanded pixel to RGB |
| out_pix | output | 24 | Selected output pixel |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_oe | output | 1 | Output bus enable, high once the pipeline is filled |

## Verification
The assertions assume that the inputs are steady across each rising edge. They also assume that `pix_en` is the only thing that decides whether a pixel is taken, so any value on the pixel, sync, window or select inputs while `pix_en` is low has to be ignored. The bench changes every input only at falling edges. It deliberately puts fresh random values on all data inputs in the cycles with `pix_en` low, and during reset. The converted case is swept over a grid that includes Y, Cb and Cr values of 0 and 255, so the saturation corners are hit in all three channels.

// File: rtl/pxo_pkg.sv
package pxo_pkg;

   // Depth of the conversion datapath; every other path is matched to it.
   localparam int CSC_LAT = 3;

   // Per-pixel control that travels alongside the data.
   typedef struct packed {
      logic hs;
      logic vs;
      logic win;
      logic cnv;
   } pxo_ctl_t;

endpackage

// File: rtl/pxo_delay.sv
module pxo_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("pxo_delay: W must be at least 1");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("pxo_delay: DEPTH must be at least 1");
   end

   logic [W-1:0] stg [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n)   stg[g] <= '0;
            else if (adv) stg[g] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n)   stg[g] <= '0;
            else if (adv) stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[DEPTH-1];

endmodule

// File: rtl/pxo_csc.sv
module pxo_csc #(
   parameter int CW   = 8,
   parameter int FRAC = 8,
   parameter int C_RV = 359,
   parameter int C_GU = 88,
   parameter int C_GV = 183,
   parameter int C_BU = 454
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [3*CW-1:0] ycc_i,
   output logic [3*CW-1:0] rgb_o
);

   localparam int PW = 3 * CW;
   localparam int AW = CW + FRAC + 4;
   localparam int KMAX = 1 << (FRAC + 1);
   localparam logic signed [AW-1:0] MID  = AW'(1 << (CW - 1));
   localparam logic signed [AW-1:0] MAXV = AW'((1 << CW) - 1);
   localparam logic signed [AW-1:0] K_RV = AW'(C_RV);
   localparam logic signed [AW-1:0] K_GU = AW'(C_GU);
   localparam logic signed [AW-1:0] K_GV = AW'(C_GV);
   localparam logic signed [AW-1:0] K_BU = AW'(C_BU);

   if (CW < 4 || CW > 12) begin : g_bad_cw
      $error("pxo_csc: CW out of range 4..12");
   end
   if (FRAC < 4 || FRAC > 12) begin : g_bad_frac
      $error("pxo_csc: FRAC out of range 4..12");
   end
   if (C_RV >= KMAX || C_GU >= KMAX || C_GV >= KMAX || C_BU >= KMAX ||
       C_RV < 0 || C_GU < 0 || C_GV < 0 || C_BU < 0) begin : g_bad_coef
      $error("pxo_csc: coefficient outside 0..2**(FRAC+1)-1");
   end

   // Unpack and center the chroma channels.
   logic [CW-1:0] y_in, cb_in, cr_in;
   logic signed [AW-1:0] cb_c, cr_c;

   assign y_in  = ycc_i[PW-1 -: CW];
   assign cb_in = ycc_i[2*CW-1 -: CW];
   assign cr_in = ycc_i[CW-1:0];
   assign cb_c  = $signed(AW'(cb_in)) - MID;
   assign cr_c  = $signed(AW'(cr_in)) - MID;

   // Stage 1: products.
   logic signed [AW-1:0] y1, pr1, pg1, pb1;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y1  <= '0;
         pr1 <= '0;
         pg1 <= '0;
         pb1 <= '0;
      end else if (adv) begin
         y1  <= $signed(AW'(y_in));
         pr1 <= K_RV * cr_c;
         pg1 <= K_GU * cb_c + K_GV * cr_c;
         pb1 <= K_BU * cb_c;
      end
   end

   // Stage 2: scale and add luma.
   logic signed [AW-1:0] r2, g2, b2;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r2 <= '0;
         g2 <= '0;
         b2 <= '0;
      end else if (adv) begin
         r2 <= y1 + (pr1 >>> FRAC);
         g2 <= y1 - (pg1 >>> FRAC);
         b2 <= y1 + (pb1 >>> FRAC);
      end
   end

   // Stage 3: clamp to the channel range.
   function automatic logic [CW-1:0] clamp(input logic signed [AW-1:0] x);
      if (x[AW-1])      return '0;
      else if (x > MAXV) return '1;
      else              return x[CW-1:0];
   endfunction

   logic [CW-1:0] r3, g3, b3;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r3 <= '0;
         g3 <= '0;
         b3 <= '0;
      end else if (adv) begin
         r3 <= clamp(r2);
         g3 <= clamp(g2);
         b3 <= clamp(b2);
      end
   end

   assign rgb_o = {r3, g3, b3};

endmodule

// File: rtl/pxo_window_out.sv
module pxo_window_out
   import pxo_pkg::*;
#(
   parameter int CW      = 8,
   parameter int DLY     = 3,
   parameter int HAS_CSC = 1,
   parameter int FRAC    = 8,
   parameter int C_RV    = 359,
   parameter int C_GU    = 88,
   parameter int C_GV    = 183,
   parameter int C_BU    = 454
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pix_en,
   input  logic [3*CW-1:0] in_pix,
   input  logic            in_hs,
   input  logic            in_vs,
   input  logic [3*CW-1:0] exp_pix,
   input  logic            win,
   input  logic            cnv_sel,
   output logic [3*CW-1:0] out_pix,
   output logic            out_hs,
   output logic            out_vs,
   output logic            out_oe
);

   localparam int PW   = 3 * CW;
   localparam int CTLW = $bits(pxo_ctl_t);
   localparam int FW   = $clog2(DLY + 1);

   if (DLY != CSC_LAT) begin : g_bad_dly
      $error("pxo_window_out: DLY must equal the conversion latency");
   end
   if (HAS_CSC != 0 && HAS_CSC != 1) begin : g_bad_has
      $error("pxo_window_out: HAS_CSC must be 0 or 1");
   end

   // Control travelling with each pixel.
   pxo_ctl_t         ctl_i, ctl_o;
   logic [CTLW-1:0]  ctl_q;

   assign ctl_i = '{hs: in_hs, vs: in_vs, win: win, cnv: cnv_sel};

   pxo_delay #(.W(CTLW), .DEPTH(DLY)) u_ctl_dly (
      .clk(clk), .rst_n(rst_n), .adv(pix_en), .d(ctl_i), .q(ctl_q)
   );
   assign ctl_o = ctl_q;

   // Pass-through path for the live pixel.
   logic [PW-1:0] in_d;
   pxo_delay #(.W(PW), .DEPTH(DLY)) u_in_dly (
      .clk(clk), .rst_n(rst_n), .adv(pix_en), .d(in_pix), .q(in_d)
   );

   // Raw expanded path, the conversion bypass.
   logic [PW-1:0] raw_d;
   pxo_delay #(.W(PW), .DEPTH(DLY)) u_raw_dly (
      .clk(clk), .rst_n(rst_n), .adv(pix_en), .d(exp_pix), .q(raw_d)
   );

   // Converted expanded path.
   logic [PW-1:0] cnv_d;
   if (HAS_CSC == 1) begin : g_csc
      pxo_csc #(
         .CW(CW), .FRAC(FRAC),
         .C_RV(C_RV), .C_GU(C_GU), .C_GV(C_GV), .C_BU(C_BU)
      ) u_csc (
         .clk(clk), .rst_n(rst_n), .adv(pix_en), .ycc_i(exp_pix), .rgb_o(cnv_d)
      );
   end else begin : g_no_csc
      assign cnv_d = raw_d;
   end

   // Final per-pixel source choice.
   always_comb begin
      if (!ctl_o.win)     out_pix = in_d;
      else if (ctl_o.cnv) out_pix = cnv_d;
      else                out_pix = raw_d;
   end

   assign out_hs = ctl_o.hs;
   assign out_vs = ctl_o.vs;

   // Output enable once the pipeline holds real pixels.
   logic [FW-1:0] fill;
   always_ff @(posedge clk) begin
      if (!rst_n)                               fill <= '0;
      else if (pix_en && fill != FW'(DLY))      fill <= fill + 1'b1;
   end
   assign out_oe = (fill == FW'(DLY));

endmodule

// File: rtl/pxo_window_out_chk.sv
module pxo_window_out_chk #(
   parameter int CW  = 8,
   parameter int DLY = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pix_en,
   input logic [3*CW-1:0] in_pix,
   input logic            in_hs,
   input logic            in_vs,
   input logic [3*CW-1:0] exp_pix,
   input logic            win,
   input logic            cnv_sel,
   input logic [3*CW-1:0] out_pix,
   input logic            out_hs,
   input logic            out_vs,
   input logic            out_oe
);

   localparam int PW = 3 * CW;
   localparam int FW = $clog2(DLY + 1);

   // Independent record of the last DLY accepted pixels.
   logic [PW-1:0]  h_in [DLY];
   logic [PW-1:0]  h_ex [DLY];
   logic [DLY-1:0] h_hs, h_vs, h_win, h_cnv;
   logic [FW-1:0]  seen;
   logic           full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DLY; i++) begin
            h_in[i] <= '0;
            h_ex[i] <= '0;
         end
         h_hs  <= '0;
         h_vs  <= '0;
         h_win <= '0;
         h_cnv <= '0;
         seen  <= '0;
      end else if (pix_en) begin
         h_in[0] <= in_pix;
         h_ex[0] <= exp_pix;
         for (int i = 1; i < DLY; i++) begin
            h_in[i] <= h_in[i-1];
            h_ex[i] <= h_ex[i-1];
         end
         h_hs  <= {h_hs[DLY-2:0], in_hs};
         h_vs  <= {h_vs[DLY-2:0], in_vs};
         h_win <= {h_win[DLY-2:0], win};
         h_cnv <= {h_cnv[DLY-2:0], cnv_sel};
         if (seen != FW'(DLY)) seen <= seen + 1'b1;
      end
   end

   assign full = (seen == FW'(DLY));

   AST_OE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      out_oe |=> out_oe); // R2

   AST_OE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      out_oe == full); // R2

   AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !h_win[DLY-1]) |-> (out_pix == h_in[DLY-1])); // R3

   AST_RAW_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (full && h_win[DLY-1] && !h_cnv[DLY-1]) |-> (out_pix == h_ex[DLY-1])); // R4

   AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (out_hs == h_hs[DLY-1] && out_vs == h_vs[DLY-1])); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(out_pix) && $stable(out_hs) && $stable(out_vs))); // R9

endmodule

bind pxo_window_out pxo_window_out_chk #(.CW(CW), .DLY(DLY)) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .in_pix(in_pix), .in_hs(in_hs),
   .in_vs(in_vs), .exp_pix(exp_pix), .win(win), .cnv_sel(cnv_sel),
   .out_pix(out_pix), .out_hs(out_hs), .out_vs(out_vs), .out_oe(out_oe)
);

// File: tb/test_pxo_window_out.sv
module test_pxo_window_out;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_en = 1'b0;
   logic [23:0] in_pix = '0;
   logic        in_hs = 1'b0;
   logic        in_vs = 1'b0;
   logic [23:0] exp_pix = '0;
   logic        win = 1'b0;
   logic        cnv_sel = 1'b0;
   logic [23:0] out_pix;
   logic        out_hs, out_vs, out_oe;

   pxo_window_out i_pxo_window_out (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .in_pix(in_pix),
      .in_hs(in_hs), .in_vs(in_vs), .exp_pix(exp_pix), .win(win),
      .cnv_sel(cnv_sel), .out_pix(out_pix), .out_hs(out_hs),
      .out_vs(out_vs), .out_oe(out_oe)
   );

   always #2 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   int adv     = 0;
   logic [31:0] seed = 32'h1234_5678;

   logic [23:0] m_in  [4];
   logic [23:0] m_ex  [4];
   logic        m_hs  [4];
   logic        m_vs  [4];
   logic        m_win [4];
   logic        m_cnv [4];

   function automatic logic [31:0] nxt(input logic [31:0] s);
      logic [31:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 17);
      t = t ^ (t << 5);
      return t;
   endfunction

   function automatic int clip(input int v);
      if (v < 0)   return 0;
      if (v > 255) return 255;
      return v;
   endfunction

   function automatic logic [23:0] csc_ref(input logic [23:0] p);
      int y, u, v, r, g, b;
      y = int'(p[23:16]);
      u = int'(p[15:8]) - 128;
      v = int'(p[7:0]) - 128;
      r = y + ((359 * v) >>> 8);
      g = y - ((88 * u + 183 * v) >>> 8);
      b = y + ((454 * u) >>> 8);
      return {clip(r)[7:0], clip(g)[7:0], clip(b)[7:0]};
   endfunction

   function automatic bit csc_sat(input logic [23:0] p);
      int y, u, v, r, g, b;
      y = int'(p[23:16]);
      u = int'(p[15:8]) - 128;
      v = int'(p[7:0]) - 128;
      r = y + ((359 * v) >>> 8);
      g = y - ((88 * u + 183 * v) >>> 8);
      b = y + ((454 * u) >>> 8);
      return (r != clip(r)) || (g != clip(g)) || (b != clip(b));
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, compare at the next falling edge.
   task automatic cycle(input logic en, input logic [23:0] ip, input logic hs,
                        input logic vs, input logic [23:0] ep, input logic w,
                        input logic c);
      logic [23:0] prev_pix;
      logic [1:0]  prev_sync;
      logic        prev_oe;
      logic [23:0] exp_pix_v;
      string       tag;
      int          k, kp;
      prev_pix  = out_pix;
      prev_sync = {out_hs, out_vs};
      prev_oe   = out_oe;
      pix_en  = en;
      in_pix  = ip;
      in_hs   = hs;
      in_vs   = vs;
      exp_pix = ep;
      win     = w;
      cnv_sel = c;
      @(posedge clk);
      if (en) begin
         m_in[adv % 4]  = ip;
         m_ex[adv % 4]  = ep;
         m_hs[adv % 4]  = hs;
         m_vs[adv % 4]  = vs;
         m_win[adv % 4] = w;
         m_cnv[adv % 4] = c;
         adv++;
      end
      @(negedge clk);
      check("R2 oe", 32'(out_oe), 32'(adv >= 3));
      if (!en) begin
         check("R9 pix hold", 32'(out_pix), 32'(prev_pix));
         check("R9 sync hold", 32'({out_hs, out_vs}), 32'(prev_sync));
         check("R9 oe hold", 32'(out_oe), 32'(prev_oe));
      end else if (adv < 3) begin
         check("R1 prefill pix", 32'(out_pix), 32'h0);
         check("R1 prefill sync", 32'({out_hs, out_vs}), 32'h0);
      end else begin
         k  = (adv - 3) % 4;
         kp = (adv - 4) % 4;
         if (!m_win[k]) begin
            exp_pix_v = m_in[k];
            tag = "R3 outside window";
         end else if (!m_cnv[k]) begin
            exp_pix_v = m_ex[k];
            tag = "R4 raw inside";
         end else begin
            exp_pix_v = csc_ref(m_ex[k]);
            tag = csc_sat(m_ex[k]) ? "R6 saturate" : "R5 convert";
         end
         if (adv >= 4 && (m_win[k] != m_win[kp] || m_cnv[k] != m_cnv[kp]))
            tag = {"R8 switch / ", tag};
         check(tag, 32'(out_pix), 32'(exp_pix_v));
         check("R7 sync align", 32'({out_hs, out_vs}), 32'({m_hs[k], m_vs[k]}));
      end
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // Reset with noise on every input.
      rst_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         seed = nxt(seed);
         pix_en  = 1'b1;
         in_pix  = seed[23:0];
         exp_pix = ~seed[23:0];
         in_hs   = seed[24];
         in_vs   = seed[25];
         win     = seed[26];
         cnv_sel = seed[27];
         @(negedge clk);
         check("R1 reset pix", 32'(out_pix), 32'h0);
         check("R1 reset sync", 32'({out_hs, out_vs}), 32'h0);
         check("R1 reset oe", 32'(out_oe), 32'h0);
      end
      rst_n = 1'b1;
      adv = 0;

      // Mixed random traffic with idle cycles.
      for (int i = 0; i < 800; i++) begin
         logic [31:0] a, b;
         seed = nxt(seed); a = seed;
         seed = nxt(seed); b = seed;
         cycle(a[1:0] != 2'b00, b[23:0], a[4], a[5], {a[31:24], b[31:24], a[15:8]},
               a[2], a[3]);
      end

      // Alternating window and select on every pixel.
      for (int i = 0; i < 64; i++) begin
         seed = nxt(seed);
         cycle(1'b1, seed[23:0], i[0], i[2], {8'(i * 4), 8'(255 - i), seed[31:24]},
               i[0], i[1]);
      end

      // Conversion sweep over a Y/Cb/Cr grid including 0 and 255.
      for (int y = 0; y < 256; y += 17) begin
         for (int cb = 0; cb < 256; cb += 17) begin
            for (int cr = 0; cr < 256; cr += 17) begin
               seed = nxt(seed);
               cycle(1'b1, seed[23:0], cb == 0, y == 0,
                     {8'(y), 8'(cb), 8'(cr)}, 1'b1, 1'b1);
            end
         end
      end

      // Drain with idle and a few trailing pixels.
      cycle(1'b0, 24'hFFFFFF, 1'b1, 1'b1, 24'h0, 1'b1, 1'b0);
      for (int i = 0; i < 4; i++) cycle(1'b1, 24'h00A5C3 + 24'(i), 1'b0, 1'b0, 24'h123456, 1'b0, 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule